// File: doc/BRIEF.md
# Sleep Control Register Decoder

This block holds the 16-bit power-management control word of a chip and turns a software write into a sleep request. Software writes either the whole word or a single byte over a little-endian register bus. When the written value has the sleep-enable bit set, the block reads the 3-bit sleep type that came with it. It then raises a single-cycle request: shutdown, suspend-to-RAM or suspend-to-disk. A disk suspend is a two-step sequence. An event pulse comes first, and a shutdown request follows on the next cycle.

The sleep-enable bit is a trigger only. It is never stored, so it always reads back as 0. All other written bits are stored. The block also owns the interrupt-routing enable bit in bit 0. Two side-band commands can set or clear that bit, as a legacy firmware handler would. An elaboration-time option builds a variant for parts that only run the native power-management model. In that variant the bit comes out of reset set, and the commands have no effect on it.

Top module: `pm_sleep_ctl`

## Requirements
- R1: Reset (synchronous, active high) clears the whole register to 0x0000. When ACPI_ONLY is 1, reset leaves 0x0001 instead, with bit 0 set. All request outputs are 0 after reset.
- R2: A word write (wr_wide=1, wr_offset ignored) stores wr_data with bit 13 forced to 0. Bit 13 (sleep enable) never reads back as 1.
- R3: A byte write (wr_wide=0) takes its byte from wr_data[7:0]. At wr_offset=1 that byte replaces bits 15:8 and bits 7:0 are kept. At wr_offset=0 it replaces bits 7:0 and bits 15:8 are kept. The merged word is both stored and decoded.
- R4: rd_data shows the stored word shifted right by 8 times rd_offset. With rd_offset=1 it reads {8'h00, bits 15:8}.
- R5: A write whose merged value has bit 13 set and sleep type (bits 12:10) equal to 0 makes shutdown_req high for exactly the one cycle after the write's clock edge.
- R6: A write with bit 13 set and sleep type 1 makes suspend_req high for exactly the one cycle after the write edge.
- R7: A write with bit 13 set and a sleep type equal to parameter S4_TYPE (other than 0 or 1; default 5) makes disk_evt high for one cycle after the write edge. shutdown_req is then high for the cycle after that.
- R8: A write with bit 13 clear, or with a sleep type that is neither 0, 1 nor S4_TYPE, raises no request output.
- R9: With ACPI_ONLY=0, sci_on_cmd sets bit 0 and sci_off_cmd clears it. If both are high, sci_on_cmd wins. A command in the same cycle as a write overrides the written bit 0.
- R10: With ACPI_ONLY=1, sci_on_cmd and sci_off_cmd are ignored, and bit 0 changes only through a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one per cycle |
| wr_wide | input | 1 | 1 = 16-bit write, 0 = byte write |
| wr_offset | input | 1 | Byte offset of a byte write |
| wr_data | input | 16 | Write data; byte writes use bits 7:0 |
| rd_offset | input | 1 | Byte offset of the read |
| rd_data | output | 16 | Stored word shifted by the read offset |
| sci_on_cmd | input | 1 | Side-band command to set bit 0 |
| sci_off_cmd | input | 1 | Side-band command to clear bit 0 |
| shutdown_req | output | 1 | One-cycle shutdown request |
| suspend_req | output | 1 | One-cycle suspend-to-RAM request |
| disk_evt | output | 1 | One-cycle suspend-to-disk event |

## Verification
The decoder is tried with every sleep type, each with the sleep bit set and cleared. This separates the shutdown, suspend and disk paths from the silent types and from writes that only store. The same types also arrive through high-byte writes, which shows the decode works on the merged word and not on the raw byte. Back-to-back writes placed right after a disk event show that the delayed shutdown combines with a new request. Commands that collide with writes, and both commands together, fix the priority on bit 0. A second instance in native-only mode receives the same commands and shows they leave its bit 0 untouched.

// File: rtl/slpctl_pkg.sv
package slpctl_pkg;

    localparam int REG_W      = 16;
    localparam int BYTE_W     = 8;
    localparam int SCI_BIT    = 0;
    localparam int SLP_EN_BIT = 13;
    localparam int TYP_LSB    = 10;
    localparam int TYP_W      = 3;

    typedef logic [REG_W-1:0] ctl_word_t;
    typedef logic [TYP_W-1:0] slp_type_t;

    typedef enum logic [1:0] {
        ACT_NONE,
        ACT_SHUTDOWN,
        ACT_SUSPEND,
        ACT_DISK
    } slp_act_e;

    typedef struct packed {
        logic      wide;
        logic      offset;
        ctl_word_t data;
    } wr_req_t;

    typedef struct packed {
        logic shutdown;
        logic suspend;
        logic disk;
    } req_pulse_t;

    // Merge a write into the current word according to its width and lane.
    function automatic ctl_word_t merge_write(input ctl_word_t cur, input wr_req_t w);
        ctl_word_t res;
        if (w.wide) begin
            res = w.data;
        end else if (w.offset) begin
            res = {w.data[BYTE_W-1:0], cur[BYTE_W-1:0]};
        end else begin
            res = {cur[REG_W-1:BYTE_W], w.data[BYTE_W-1:0]};
        end
        return res;
    endfunction

    // Map the sleep trigger and its type onto a request kind.
    function automatic slp_act_e classify(input logic trig, input slp_type_t typ,
                                          input slp_type_t disk_typ);
        slp_act_e act;
        if (!trig) begin
            act = ACT_NONE;
        end else if (typ == slp_type_t'(0)) begin
            act = ACT_SHUTDOWN;
        end else if (typ == slp_type_t'(1)) begin
            act = ACT_SUSPEND;
        end else if (typ == disk_typ) begin
            act = ACT_DISK;
        end else begin
            act = ACT_NONE;
        end
        return act;
    endfunction

endpackage

// File: rtl/slpctl_wmerge.sv
module slpctl_wmerge
    import slpctl_pkg::*;
(
    input  ctl_word_t cur_word,
    input  wr_req_t   req,
    output ctl_word_t merged
);

    always_comb begin
        merged = merge_write(cur_word, req);
    end

endmodule

// File: rtl/slpctl_decode.sv
module slpctl_decode
    import slpctl_pkg::*;
#(
    parameter int unsigned DISK_TYPE = 5
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic       trig,
    input  slp_type_t  typ,
    output req_pulse_t pulses
);

    localparam slp_type_t DISK_TYP_L = slp_type_t'(DISK_TYPE);

    slp_act_e   act;
    req_pulse_t pulse_d;
    req_pulse_t pulse_q;

    always_comb begin
        act              = wr_en ? classify(trig, typ, DISK_TYP_L) : ACT_NONE;
        pulse_d.shutdown = (act == ACT_SHUTDOWN) || pulse_q.disk;
        pulse_d.suspend  = (act == ACT_SUSPEND);
        pulse_d.disk     = (act == ACT_DISK);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pulse_q <= '0;
        end else begin
            pulse_q <= pulse_d;
        end
    end

    assign pulses = pulse_q;

    // R6
    susp_after_wr_chk: assert property (@(posedge clk) disable iff (rst)
        pulse_q.suspend |-> $past(wr_en));

    // R7
    disk_then_shut_chk: assert property (@(posedge clk) disable iff (rst)
        pulse_q.disk |=> pulse_q.shutdown);

endmodule

// File: rtl/slpctl_sci.sv
module slpctl_sci #(
    parameter bit NATIVE_ONLY = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic wr_en,
    input  logic wr_bit,
    input  logic cmd_on,
    input  logic cmd_off,
    output logic sci_q
);

    generate
        if (NATIVE_ONLY) begin : g_native
            logic unused_cmds;
            assign unused_cmds = cmd_on ^ cmd_off;

            always_ff @(posedge clk) begin
                if (rst) begin
                    sci_q <= 1'b1;
                end else if (wr_en) begin
                    sci_q <= wr_bit;
                end
            end

            // R10
            cmd_ignored_chk: assert property (@(posedge clk) disable iff (rst)
                !wr_en |=> $stable(sci_q));
        end else begin : g_legacy
            always_ff @(posedge clk) begin
                if (rst) begin
                    sci_q <= 1'b0;
                end else if (cmd_on) begin
                    sci_q <= 1'b1;
                end else if (cmd_off) begin
                    sci_q <= 1'b0;
                end else if (wr_en) begin
                    sci_q <= wr_bit;
                end
            end

            // R9
            cmd_on_sets_chk: assert property (@(posedge clk) disable iff (rst)
                cmd_on |=> sci_q);
        end
    endgenerate

endmodule

// File: rtl/pm_sleep_ctl.sv
module pm_sleep_ctl
    import slpctl_pkg::*;
#(
    parameter int unsigned S4_TYPE   = 5,
    parameter bit          ACPI_ONLY = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             wr_wide,
    input  logic             wr_offset,
    input  logic [REG_W-1:0] wr_data,
    input  logic             rd_offset,
    output logic [REG_W-1:0] rd_data,
    input  logic             sci_on_cmd,
    input  logic             sci_off_cmd,
    output logic             shutdown_req,
    output logic             suspend_req,
    output logic             disk_evt
);

    localparam int HI_W = REG_W - 1;

    ctl_word_t          word_q;
    ctl_word_t          merged;
    wr_req_t            req;
    logic [HI_W-1:0]    upper_q;
    logic               sci_q;
    req_pulse_t         pulses;

    assign req.wide   = wr_wide;
    assign req.offset = wr_offset;
    assign req.data   = wr_data;

    slpctl_wmerge u_merge (
        .cur_word (word_q),
        .req      (req),
        .merged   (merged)
    );

    slpctl_decode #(
        .DISK_TYPE (S4_TYPE)
    ) u_decode (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .trig   (merged[SLP_EN_BIT]),
        .typ    (merged[TYP_LSB +: TYP_W]),
        .pulses (pulses)
    );

    slpctl_sci #(
        .NATIVE_ONLY (ACPI_ONLY)
    ) u_sci (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_bit  (merged[SCI_BIT]),
        .cmd_on  (sci_on_cmd),
        .cmd_off (sci_off_cmd),
        .sci_q   (sci_q)
    );

    // Bits above bit 0 are stored here; the trigger bit is dropped on the way in.
    always_ff @(posedge clk) begin
        if (rst) begin
            upper_q <= '0;
        end else if (wr_en) begin
            upper_q                 <= merged[REG_W-1:1];
            upper_q[SLP_EN_BIT - 1] <= 1'b0;
        end
    end

    assign word_q       = {upper_q, sci_q};
    assign rd_data      = rd_offset ? {{BYTE_W{1'b0}}, word_q[REG_W-1:BYTE_W]} : word_q;
    assign shutdown_req = pulses.shutdown;
    assign suspend_req  = pulses.suspend;
    assign disk_evt     = pulses.disk;

    // R2
    slp_bit_hidden_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_offset == 1'b0) |-> (rd_data[SLP_EN_BIT] == 1'b0));

    // R5
    shut_cause_chk: assert property (@(posedge clk) disable iff (rst)
        shutdown_req |-> ($past(wr_en) || $past(disk_evt)));

endmodule

// File: tb/pm_sleep_ctl_bench.sv
module pm_sleep_ctl_bench;

    localparam int S4 = 5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0, wr_wide = 1'b0, wr_offset = 1'b0;
    logic [15:0] wr_data = '0;
    logic        rd_offset = 1'b0;
    logic        sci_on_cmd = 1'b0, sci_off_cmd = 1'b0;
    logic [15:0] rd_data, rd_data_ao;
    logic        shutdown_req, suspend_req, disk_evt;
    logic        sd_ao, su_ao, dk_ao;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    logic [15:0] m_reg, m_ao;
    logic        prev_disk;

    always #2 clk = ~clk;

    pm_sleep_ctl #(.S4_TYPE(S4), .ACPI_ONLY(1'b0)) u_pm_sleep_ctl (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_wide(wr_wide), .wr_offset(wr_offset),
        .wr_data(wr_data), .rd_offset(rd_offset), .rd_data(rd_data),
        .sci_on_cmd(sci_on_cmd), .sci_off_cmd(sci_off_cmd),
        .shutdown_req(shutdown_req), .suspend_req(suspend_req), .disk_evt(disk_evt));

    pm_sleep_ctl #(.S4_TYPE(S4), .ACPI_ONLY(1'b1)) u_pm_sleep_ctl_ao (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_wide(wr_wide), .wr_offset(wr_offset),
        .wr_data(wr_data), .rd_offset(rd_offset), .rd_data(rd_data_ao),
        .sci_on_cmd(sci_on_cmd), .sci_off_cmd(sci_off_cmd),
        .shutdown_req(sd_ao), .suspend_req(su_ao), .disk_evt(dk_ao));

    function automatic logic [15:0] exp_merge(input logic [15:0] cur, input logic wide,
                                              input logic ofs, input logic [15:0] d);
        if (wide) return d;
        if (ofs)  return {d[7:0], cur[7:0]};
        return {cur[15:8], d[7:0]};
    endfunction

    // 0 none, 1 shutdown, 2 suspend, 3 disk
    function automatic int exp_kind(input logic [15:0] v);
        if (!v[13]) return 0;
        if (v[12:10] == 3'd0) return 1;
        if (v[12:10] == 3'd1) return 2;
        if (v[12:10] == 3'(S4)) return 3;
        return 0;
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: got 0x%04h expected 0x%04h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; wr_en = 1'b0; sci_on_cmd = 1'b0; sci_off_cmd = 1'b0; rd_offset = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        m_reg = 16'h0000; m_ao = 16'h0001; prev_disk = 1'b0;
        check("R1 reset word", rd_data, 16'h0000);
        check("R1 reset word native-only", rd_data_ao, 16'h0001);
        check("R1 reset requests", {13'd0, shutdown_req, suspend_req, disk_evt}, 16'd0);
    endtask

    // Called at a negedge; applies one cycle of stimulus and checks at the next negedge.
    task automatic run_op(input logic we, input logic wide, input logic ofs,
                          input logic [15:0] d, input logic on, input logic off,
                          input logic rofs);
        logic [15:0] mg, mg_ao, exp_rd, exp_rd_ao;
        logic        e_sd, e_su, e_dk;
        int          k;
        string       ptag, rtag;
        wr_en = we; wr_wide = wide; wr_offset = ofs; wr_data = d;
        sci_on_cmd = on; sci_off_cmd = off; rd_offset = rofs;
        mg    = exp_merge(m_reg, wide, ofs, d);
        mg_ao = exp_merge(m_ao, wide, ofs, d);
        k     = we ? exp_kind(mg) : 0;
        e_dk  = (k == 3);
        e_su  = (k == 2);
        e_sd  = (k == 1) || prev_disk;
        prev_disk = e_dk;
        if (we) begin
            m_reg[15:1] = mg[15:1]; m_reg[13] = 1'b0;
            m_ao        = mg_ao;    m_ao[13]  = 1'b0;
        end
        if (on)       m_reg[0] = 1'b1;
        else if (off) m_reg[0] = 1'b0;
        else if (we)  m_reg[0] = mg[0];
        @(negedge clk);
        exp_rd    = m_reg >> (8 * int'(rofs));
        exp_rd_ao = m_ao  >> (8 * int'(rofs));
        rtag = rofs ? "R4 read high" : (!we ? "R9 word" : (wide ? "R2 word" : "R3 byte"));
        check(rtag, rd_data, exp_rd);
        check((on || off) ? "R10 native-only word" : "R2 native-only word",
              rd_data_ao, exp_rd_ao);
        if (k == 1)      ptag = "R5 shutdown";
        else if (k == 2) ptag = "R6 suspend";
        else if (k == 3) ptag = "R7 disk";
        else if (e_sd)   ptag = "R7 follow shutdown";
        else             ptag = "R8 no request";
        check(ptag, {13'd0, shutdown_req, suspend_req, disk_evt}, {13'd0, e_sd, e_su, e_dk});
    endtask

    initial begin
        void'($urandom(32'd4242));
        do_reset();
        // Directed corner cases
        run_op(1, 1, 0, 16'h0005, 0, 0, 0);  // R2 store, no trigger
        run_op(1, 1, 0, 16'h2000, 0, 0, 0);  // R5 type 0
        run_op(0, 0, 0, 16'h0000, 0, 0, 0);  // pulse drops
        run_op(1, 1, 1, 16'h2401, 0, 0, 0);  // R6 type 1, offset ignored for word
        run_op(1, 1, 0, 16'h3400, 0, 0, 1);  // R7 type 5
        run_op(0, 0, 0, 16'h0000, 0, 0, 0);  // R7 shutdown follows
        run_op(1, 1, 0, 16'h2800, 0, 0, 0);  // R8 type 2 silent
        run_op(1, 1, 0, 16'h1400, 0, 0, 0);  // R8 type 5 without trigger
        run_op(1, 1, 0, 16'h00A5, 0, 0, 0);
        run_op(1, 0, 1, 16'hFF24, 0, 0, 0);  // R3 high byte type 1 -> suspend
        run_op(1, 0, 0, 16'h005A, 0, 0, 1);  // R3 low byte keeps high
        run_op(1, 0, 1, 16'h0034, 0, 0, 0);  // R3 high byte type 5 -> disk
        run_op(1, 1, 0, 16'h2000, 0, 0, 0);  // R7 follow plus new shutdown
        run_op(0, 0, 0, 16'h0000, 1, 0, 0);  // R9 on
        run_op(0, 0, 0, 16'h0000, 0, 1, 0);  // R9 off
        run_op(0, 0, 0, 16'h0000, 1, 1, 0);  // R9 on wins
        run_op(1, 1, 0, 16'h0001, 0, 1, 0);  // R9 command over write
        run_op(1, 1, 0, 16'h0000, 1, 0, 0);  // R9 command over write
        // Random traffic
        for (int i = 0; i < 3000; i++) begin
            logic [15:0] d;
            d = 16'($urandom);
            if ($urandom % 3 != 0) d[13] = 1'b1;
            if (i == 1500) do_reset();
            run_op(($urandom % 4) != 0, $urandom % 2, $urandom % 2, d,
                   ($urandom % 8) == 0, ($urandom % 8) == 0, $urandom % 2);
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

endmodule